// File: doc/BRIEF.md
# Floppy DMA Register Front End

This block sits between an 8-bit processor bus and a floppy disk controller. Software sees four byte-wide registers. They hold a drive-select byte, a control byte and a 16-bit transfer address. A 4-bit bank field in the control byte extends that address to 20 bits. Reads return a status byte that tracks the controller's data-request and interrupt lines together with a few drive condition inputs. Reads also return the two address bytes.

When transfers are enabled, each data request from the controller moves one byte. With the direction bit clear, the byte goes from the controller into memory. With it set, the byte goes from memory to the controller. Every memory access uses a request/acknowledge handshake. After each byte the 20-bit address advances by one, and the carry runs into the bank bits. An interrupt output combines the control byte's interrupt enable with the tracked controller interrupt.

Top module: `fdc_dma_bridge`

## Requirements
- R1: After reset the status byte, the control byte, both address bytes, the 4-bit bank and the drive-select byte are all zero. `irqOut` and `memReq` are low.
- R2: Reads are combinational on `busRdata`. Offset 0 returns status, offset 2 returns the address high byte, offset 3 returns the address low byte, and offset 1 returns 0xFF.
- R3: A write (`busEn` and `busWe` at a clock edge) stores into the register at its offset. Offset 0 is drive select, offset 1 is control, offset 2 is the address high byte and offset 3 is the address low byte. A write to one address byte leaves the other byte unchanged.
- R4: One cycle after its inputs, the status byte holds the following: bit 7 is `fdcDrq`, bit 6 is `fdcIntrq`, bit 5 is `motorDelay`, bit 4 is control bit 4, bit 3 is `driveFault`, bit 2 is `driveSize`, bit 1 is zero and bit 0 is `dipSense`.
- R5: `driveSel` always shows the drive-select byte. `sideSel` always shows control bit 6.
- R6: Direction 0 applies when control bit 5 is 0. When control bit 4 (enable) is set and `fdcDrq` is high in the idle state, `fdcRd` pulses for one cycle. The byte on `fdcDataIn` is captured in that cycle. That byte is then written to memory (`memReq`, `memWe` high) at the address {control[3:0], high, low}.
- R7: Direction 1 applies when control bit 5 is 1. The block issues a memory read (`memReq` high, `memWe` low). When it is acknowledged, `memRdata` is captured. A one-cycle `fdcWr` pulse then follows, with that byte on `fdcDataOut`.
- R8: Each completed transfer advances the 20-bit address by one. The carry out of the low 16 bits goes into the bank.
- R9: With control bit 4 clear, `fdcDrq` starts no transfer and the address does not move.
- R10: `irqOut` is high exactly while control bit 7 and status bit 6 are both set.
- R11: `memReq`, `memWe` and `memAddr` stay steady until `memAck`. A new data request is not taken before the current transfer completes.
- R12: A bus write to an address byte or to the control byte may land in the cycle when the address advances. In that case the advance is applied first, and the written field then replaces its part of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Register access strobe |
| busWe | input | 1 | Write qualifier for busEn |
| busOffs | input | 2 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data |
| fdcDrq | input | 1 | Controller data request |
| fdcIntrq | input | 1 | Controller interrupt request |
| motorDelay | input | 1 | Motor delay condition |
| driveFault | input | 1 | Drive fault condition |
| driveSize | input | 1 | Drive size sense |
| dipSense | input | 1 | Configuration switch sense |
| fdcDataIn | input | 8 | Byte from the controller data port |
| fdcRd | output | 1 | One-cycle read of the controller data port |
| fdcWr | output | 1 | One-cycle write of the controller data port |
| fdcDataOut | output | 8 | Byte to the controller data port |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 20 | Memory address {bank, high, low} |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data |
| memAck | input | 1 | Memory acknowledge |
| driveSel | output | 8 | Drive-select register |
| sideSel | output | 1 | Side select from control bit 6 |
| irqOut | output | 1 | Gated interrupt |

## Verification
A processor write to the address low byte can land in the same cycle as the post-transfer advance of the address counter. The bench provokes this with a manual acknowledge: it asserts `memAck` on the same half-cycle as the bus write to offset 3, with the address sitting at 0x12FF. Reading back 0x13 and 0x80 shows that the carry into the high byte survived and the written low byte won. The carry path into the bank, and a second data request raised while a slow acknowledge is pending, are judged by the order and addresses of the memory accesses the scoreboard sees.

// File: rtl/fdc_dma_pkg.sv
`timescale 1ns/1ps
package fdc_dma_pkg;

  typedef enum logic [1:0] {
    XFER_IDLE = 2'd0,
    XFER_MEM  = 2'd1,
    XFER_PUSH = 2'd2
  } xferState_t;

  // strobes from the sequencer to the datapath and the pins
  typedef struct packed {
    logic fdcRd;
    logic fdcWr;
    logic memReq;
    logic memWe;
    logic capMem;
    logic advance;
  } xferStrobe_t;

  localparam logic [1:0] OFFS_DRIVE = 2'd0;
  localparam logic [1:0] OFFS_CTRL  = 2'd1;
  localparam logic [1:0] OFFS_HI    = 2'd2;
  localparam logic [1:0] OFFS_LO    = 2'd3;

  localparam int CTL_IRQ_BIT  = 7;
  localparam int CTL_SIDE_BIT = 6;
  localparam int CTL_DIR_BIT  = 5;
  localparam int CTL_EN_BIT   = 4;

endpackage

// File: rtl/fdc_dma_seq.sv
`timescale 1ns/1ps
module fdc_dma_seq
  import fdc_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dmaEn,
  input  logic        dmaDir,
  input  logic        fdcDrq,
  input  logic        memAck,
  output xferStrobe_t strobe
);

  xferState_t state, stateNext;
  logic       dirHold, dirHoldNext;

  always_comb begin
    strobe      = '0;
    stateNext   = state;
    dirHoldNext = dirHold;
    unique case (state)
      XFER_IDLE: begin
        if (dmaEn && fdcDrq) begin
          dirHoldNext  = dmaDir;
          strobe.fdcRd = !dmaDir;
          stateNext    = XFER_MEM;
        end
      end
      XFER_MEM: begin
        strobe.memReq = 1'b1;
        strobe.memWe  = !dirHold;
        if (memAck) begin
          if (dirHold) begin
            strobe.capMem = 1'b1;
            stateNext     = XFER_PUSH;
          end else begin
            strobe.advance = 1'b1;
            stateNext      = XFER_IDLE;
          end
        end
      end
      XFER_PUSH: begin
        strobe.fdcWr   = 1'b1;
        strobe.advance = 1'b1;
        stateNext      = XFER_IDLE;
      end
      default: stateNext = XFER_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= XFER_IDLE;
      dirHold <= 1'b0;
    end else begin
      state   <= stateNext;
      dirHold <= dirHoldNext;
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.memReq && !memAck) |=> (strobe.memReq && $stable(strobe.memWe)));

  // R6
  rd_then_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fdcRd |=> (strobe.memReq && strobe.memWe));

  // R7
  push_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fdcWr |-> ($past(memAck) && $past(strobe.memReq) && !$past(strobe.memWe)));

endmodule

// File: rtl/fdc_dma_path.sv
`timescale 1ns/1ps
module fdc_dma_path
  import fdc_dma_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int BANK_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busEn,
  input  logic                       busWe,
  input  logic [1:0]                 busOffs,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  input  logic                       fdcDrq,
  input  logic                       fdcIntrq,
  input  logic                       motorDelay,
  input  logic                       driveFault,
  input  logic                       driveSize,
  input  logic                       dipSense,
  input  logic                       fdcRdStb,
  input  logic                       capMemStb,
  input  logic                       advanceStb,
  input  logic [DATA_W-1:0]          fdcDataIn,
  input  logic [DATA_W-1:0]          memRdata,
  output logic [DATA_W-1:0]          dataOut,
  output logic [ADDR_W+BANK_W-1:0]   memAddr,
  output logic [DATA_W-1:0]          driveSel,
  output logic                       sideSel,
  output logic                       dmaEn,
  output logic                       dmaDir,
  output logic                       irqOut
);

  localparam int FULL_W  = ADDR_W + BANK_W;
  localparam int HALF_W  = ADDR_W / 2;
  localparam int FLAG_W  = DATA_W - BANK_W;
  localparam int FLAG_IRQ  = CTL_IRQ_BIT  - BANK_W;
  localparam int FLAG_SIDE = CTL_SIDE_BIT - BANK_W;
  localparam int FLAG_DIR  = CTL_DIR_BIT  - BANK_W;
  localparam int FLAG_EN   = CTL_EN_BIT   - BANK_W;

  logic [DATA_W-1:0] driveReg;
  logic [FLAG_W-1:0] ctrlFlags;
  logic [FULL_W-1:0] addrReg, addrNext, addrStep;
  logic [DATA_W-1:0] statusReg;
  logic [DATA_W-1:0] dataLatch;
  logic              wrDrive, wrCtrl, wrHi, wrLo, addrWrite;

  assign wrDrive   = busEn && busWe && (busOffs == OFFS_DRIVE);
  assign wrCtrl    = busEn && busWe && (busOffs == OFFS_CTRL);
  assign wrHi      = busEn && busWe && (busOffs == OFFS_HI);
  assign wrLo      = busEn && busWe && (busOffs == OFFS_LO);
  assign addrWrite = wrCtrl || wrHi || wrLo;

  // advance first, then let a bus write replace its own field
  always_comb begin
    addrStep = advanceStb ? addrReg + FULL_W'(1) : addrReg;
    addrNext = addrStep;
    if (wrCtrl) addrNext[FULL_W-1:ADDR_W]  = busWdata[BANK_W-1:0];
    if (wrHi)   addrNext[ADDR_W-1:HALF_W]  = busWdata;
    if (wrLo)   addrNext[HALF_W-1:0]       = busWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      driveReg  <= '0;
      ctrlFlags <= '0;
      addrReg   <= '0;
      statusReg <= '0;
      dataLatch <= '0;
    end else begin
      statusReg <= {fdcDrq, fdcIntrq, motorDelay, ctrlFlags[FLAG_EN],
                    driveFault, driveSize, 1'b0, dipSense};
      if (wrDrive) driveReg  <= busWdata;
      if (wrCtrl)  ctrlFlags <= busWdata[DATA_W-1:BANK_W];
      addrReg <= addrNext;
      if (fdcRdStb)       dataLatch <= fdcDataIn;
      else if (capMemStb) dataLatch <= memRdata;
    end
  end

  always_comb begin
    unique case (busOffs)
      OFFS_DRIVE: busRdata = statusReg;
      OFFS_HI:    busRdata = addrReg[ADDR_W-1:HALF_W];
      OFFS_LO:    busRdata = addrReg[HALF_W-1:0];
      default:    busRdata = '1;
    endcase
  end

  assign dataOut  = dataLatch;
  assign memAddr  = addrReg;
  assign driveSel = driveReg;
  assign sideSel  = ctrlFlags[FLAG_SIDE];
  assign dmaEn    = ctrlFlags[FLAG_EN];
  assign dmaDir   = ctrlFlags[FLAG_DIR];
  assign irqOut   = ctrlFlags[FLAG_IRQ] && statusReg[CTL_IRQ_BIT-1];

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advanceStb && !addrWrite) |=> (addrReg == $past(addrReg) + FULL_W'(1)));

  // R4
  status_intrq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fdcIntrq) |=> statusReg[6]);

  // R9
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaEn && !advanceStb && !addrWrite) |=> $stable(addrReg));

endmodule

// File: rtl/fdc_dma_bridge.sv
`timescale 1ns/1ps
module fdc_dma_bridge
  import fdc_dma_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int BANK_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busEn,
  input  logic                     busWe,
  input  logic [1:0]               busOffs,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  input  logic                     fdcDrq,
  input  logic                     fdcIntrq,
  input  logic                     motorDelay,
  input  logic                     driveFault,
  input  logic                     driveSize,
  input  logic                     dipSense,
  input  logic [DATA_W-1:0]        fdcDataIn,
  output logic                     fdcRd,
  output logic                     fdcWr,
  output logic [DATA_W-1:0]        fdcDataOut,
  output logic                     memReq,
  output logic                     memWe,
  output logic [ADDR_W+BANK_W-1:0] memAddr,
  output logic [DATA_W-1:0]        memWdata,
  input  logic [DATA_W-1:0]        memRdata,
  input  logic                     memAck,
  output logic [DATA_W-1:0]        driveSel,
  output logic                     sideSel,
  output logic                     irqOut
);

  xferStrobe_t       strobe;
  logic              dmaEn, dmaDir;
  logic [DATA_W-1:0] dataOut;

  fdc_dma_seq i_seq (
    .clk    (clk),
    .rstN   (rstN),
    .dmaEn  (dmaEn),
    .dmaDir (dmaDir),
    .fdcDrq (fdcDrq),
    .memAck (memAck),
    .strobe (strobe)
  );

  fdc_dma_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .busEn      (busEn),
    .busWe      (busWe),
    .busOffs    (busOffs),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .fdcDrq     (fdcDrq),
    .fdcIntrq   (fdcIntrq),
    .motorDelay (motorDelay),
    .driveFault (driveFault),
    .driveSize  (driveSize),
    .dipSense   (dipSense),
    .fdcRdStb   (strobe.fdcRd),
    .capMemStb  (strobe.capMem),
    .advanceStb (strobe.advance),
    .fdcDataIn  (fdcDataIn),
    .memRdata   (memRdata),
    .dataOut    (dataOut),
    .memAddr    (memAddr),
    .driveSel   (driveSel),
    .sideSel    (sideSel),
    .dmaEn      (dmaEn),
    .dmaDir     (dmaDir),
    .irqOut     (irqOut)
  );

  assign fdcRd      = strobe.fdcRd;
  assign fdcWr      = strobe.fdcWr;
  assign memReq     = strobe.memReq;
  assign memWe      = strobe.memWe;
  assign fdcDataOut = dataOut;
  assign memWdata   = dataOut;

endmodule

// File: tb/test_fdc_dma_bridge.sv
`timescale 1ns/1ps
module test_fdc_dma_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0, busWe = 1'b0;
  logic [1:0]  busOffs = 2'd0;
  logic [7:0]  busWdata = 8'h00, busRdata;
  logic        fdcDrq = 1'b0, fdcIntrq = 1'b0;
  logic        motorDelay = 1'b0, driveFault = 1'b0, driveSize = 1'b0, dipSense = 1'b0;
  logic [7:0]  fdcDataIn = 8'h00, fdcDataOut;
  logic        fdcRd, fdcWr, memReq, memWe;
  logic [19:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic        memAck, autoAck = 1'b0, manAck = 1'b0;
  logic [7:0]  driveSel;
  logic        sideSel, irqOut;

  int checks = 0, errors = 0;
  int ackDelay = 1, waitCnt = 0;
  bit manualMode = 1'b0;
  int raiseCnt = 0, raiseSeen = 0;
  bit dropPend = 1'b0;

  typedef struct { bit toFdc; bit we; logic [19:0] addr; logic [7:0] data; } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  assign memAck   = autoAck | manAck;
  assign memRdata = memAddr[7:0] ^ 8'hA5;

  fdc_dma_bridge i_fdc_dma_bridge (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busOffs(busOffs),
    .busWdata(busWdata), .busRdata(busRdata), .fdcDrq(fdcDrq), .fdcIntrq(fdcIntrq),
    .motorDelay(motorDelay), .driveFault(driveFault), .driveSize(driveSize),
    .dipSense(dipSense), .fdcDataIn(fdcDataIn), .fdcRd(fdcRd), .fdcWr(fdcWr),
    .fdcDataOut(fdcDataOut), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .driveSel(driveSel),
    .sideSel(sideSel), .irqOut(irqOut)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model with programmable acknowledge latency
  always @(negedge clk) begin
    if (autoAck) autoAck <= 1'b0;
    else if (memReq && !manualMode) begin
      if (waitCnt >= ackDelay) begin autoAck <= 1'b1; waitCnt <= 0; end
      else waitCnt <= waitCnt + 1;
    end
  end

  // controller model: request drops after the block touches the data port
  always @(negedge clk) begin
    if (dropPend) begin fdcDrq = 1'b0; dropPend = 1'b0; end
    else if (raiseCnt != raiseSeen) begin fdcDrq = 1'b1; raiseSeen = raiseCnt; end
    #0.5;
    if (fdcRd || fdcWr) dropPend = 1'b1;
  end

  // monitor: pops expected transfers and compares
  always @(negedge clk) begin
    item_t exp;
    #0.5;
    if (rstN && ((memReq && memAck) || fdcWr)) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected transfer: actual memAddr %0h expected none", memAddr);
      end else begin
        exp = sb.pop_front();
        if (fdcWr) begin
          check("R7", "kind fdc", 32'(exp.toFdc), 32'd1);
          check("R7", "fdc byte", 32'(fdcDataOut), 32'(exp.data));
        end else begin
          check("R11", "kind mem", 32'(exp.toFdc), 32'd0);
          check("R6", "mem we", 32'(memWe), 32'(exp.we));
          check("R8", "mem addr", 32'(memAddr), 32'(exp.addr));
          if (exp.we) check("R6", "mem data", 32'(memWdata), 32'(exp.data));
        end
      end
    end
  end

  task automatic regWrite(logic [1:0] offs, logic [7:0] data);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b1; busOffs = offs; busWdata = data;
    @(negedge clk);
    busEn = 1'b0; busWe = 1'b0;
  endtask

  task automatic regRead(logic [1:0] offs, output logic [7:0] data);
    @(negedge clk);
    busOffs = offs;
    #0.5;
    data = busRdata;
  endtask

  task automatic raiseDrq(logic [7:0] b);
    @(negedge clk);
    fdcDataIn = b;
    raiseCnt++;
  endtask

  task automatic pushMem(bit we, logic [19:0] a, logic [7:0] d);
    item_t it;
    it.toFdc = 1'b0; it.we = we; it.addr = a; it.data = d;
    sb.push_back(it);
  endtask

  task automatic pushFdc(logic [7:0] d);
    item_t it;
    it.toFdc = 1'b1; it.we = 1'b0; it.addr = '0; it.data = d;
    sb.push_back(it);
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 300 && sb.size() != 0; i++) @(negedge clk);
    check(req, "scoreboard drained", 32'(sb.size()), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    regRead(2'd0, rd); check("R1", "status", 32'(rd), 32'h00);
    regRead(2'd2, rd); check("R1", "addr hi", 32'(rd), 32'h00);
    regRead(2'd3, rd); check("R1", "addr lo", 32'(rd), 32'h00);
    check("R1", "memAddr", 32'(memAddr), 32'h0);
    check("R1", "driveSel", 32'(driveSel), 32'h00);
    check("R1", "irqOut", 32'(irqOut), 32'd0);
    check("R1", "memReq", 32'(memReq), 32'd0);

    // R2 unmapped read
    regRead(2'd1, rd); check("R2", "offset1 read", 32'(rd), 32'hFF);

    // R3 address halves
    regWrite(2'd2, 8'h12); regWrite(2'd3, 8'h34);
    regRead(2'd2, rd); check("R3", "hi", 32'(rd), 32'h12);
    regRead(2'd3, rd); check("R3", "lo", 32'(rd), 32'h34);
    regWrite(2'd2, 8'hAB);
    regRead(2'd3, rd); check("R3", "lo kept", 32'(rd), 32'h34);
    regRead(2'd2, rd); check("R3", "hi replaced", 32'(rd), 32'hAB);

    // R5 select outputs
    regWrite(2'd0, 8'h54);
    check("R5", "driveSel", 32'(driveSel), 32'h54);
    regWrite(2'd1, 8'h40);
    check("R5", "sideSel", 32'(sideSel), 32'd1);

    // R4 status layout
    @(negedge clk); motorDelay = 1'b1; driveFault = 1'b1; dipSense = 1'b1;
    repeat (2) @(negedge clk);
    regRead(2'd0, rd); check("R4", "status pattern a", 32'(rd), 32'h29);
    @(negedge clk); motorDelay = 1'b0; dipSense = 1'b0; driveSize = 1'b1;
    repeat (2) @(negedge clk);
    regRead(2'd0, rd); check("R4", "status pattern b", 32'(rd), 32'h0C);
    @(negedge clk); driveFault = 1'b0; driveSize = 1'b0;

    // R10 interrupt gating
    regWrite(2'd1, 8'h80);
    @(negedge clk); fdcIntrq = 1'b1;
    repeat (2) @(negedge clk);
    check("R10", "irq on", 32'(irqOut), 32'd1);
    regRead(2'd0, rd); check("R4", "status intrq", 32'(rd), 32'h40);
    regWrite(2'd1, 8'h00);
    check("R10", "irq off by enable", 32'(irqOut), 32'd0);
    regWrite(2'd1, 8'h80);
    @(negedge clk); fdcIntrq = 1'b0;
    repeat (2) @(negedge clk);
    check("R10", "irq off by line", 32'(irqOut), 32'd0);

    // R9 disabled: request ignored, then taken once enabled
    regWrite(2'd1, 8'h00); regWrite(2'd2, 8'h05); regWrite(2'd3, 8'h00);
    raiseDrq(8'h3C);
    repeat (10) @(negedge clk);
    check("R9", "no memReq", 32'(memReq), 32'd0);
    regRead(2'd3, rd); check("R9", "addr lo unmoved", 32'(rd), 32'h00);
    regRead(2'd0, rd); check("R4", "status drq", 32'(rd), 32'h80);
    pushMem(1'b1, 20'h00500, 8'h3C);
    regWrite(2'd1, 8'h10);
    drain("R9");

    // R6 R8 carry into bank
    regWrite(2'd1, 8'h13); regWrite(2'd2, 8'hFF); regWrite(2'd3, 8'hFE);
    pushMem(1'b1, 20'h3FFFE, 8'h11); raiseDrq(8'h11); drain("R6");
    pushMem(1'b1, 20'h3FFFF, 8'h22); raiseDrq(8'h22); drain("R6");
    pushMem(1'b1, 20'h40000, 8'h33); raiseDrq(8'h33); drain("R8");
    regRead(2'd2, rd); check("R8", "hi after carry", 32'(rd), 32'h00);
    regRead(2'd3, rd); check("R8", "lo after carry", 32'(rd), 32'h01);

    // R7 memory to controller
    regWrite(2'd1, 8'h30); regWrite(2'd2, 8'h20); regWrite(2'd3, 8'h10);
    pushMem(1'b0, 20'h02010, 8'h00); pushFdc(8'h10 ^ 8'hA5);
    raiseDrq(8'h00); drain("R7");
    regRead(2'd3, rd); check("R8", "lo after read xfer", 32'(rd), 32'h11);

    // R11 slow acknowledge, second request raised while waiting
    ackDelay = 8;
    regWrite(2'd1, 8'h10); regWrite(2'd2, 8'h40); regWrite(2'd3, 8'h00);
    pushMem(1'b1, 20'h04000, 8'hA1); pushMem(1'b1, 20'h04001, 8'hB2);
    raiseDrq(8'hA1);
    repeat (4) @(negedge clk);
    raiseDrq(8'hB2);
    @(negedge clk); #0.5;
    check("R11", "req held", 32'(memReq), 32'd1);
    check("R11", "addr held", 32'(memAddr), 32'h04000);
    drain("R11");
    ackDelay = 1;

    // R12 bus write in the advance cycle
    regWrite(2'd1, 8'h10); regWrite(2'd2, 8'h12); regWrite(2'd3, 8'hFF);
    manualMode = 1'b1;
    pushMem(1'b1, 20'h012FF, 8'h77);
    raiseDrq(8'h77);
    for (int i = 0; i < 50 && !memReq; i++) @(negedge clk);
    @(negedge clk);
    manAck = 1'b1; busEn = 1'b1; busWe = 1'b1; busOffs = 2'd3; busWdata = 8'h80;
    @(negedge clk);
    manAck = 1'b0; busEn = 1'b0; busWe = 1'b0;
    manualMode = 1'b0;
    drain("R12");
    regRead(2'd2, rd); check("R12", "hi carried", 32'(rd), 32'h13);
    regRead(2'd3, rd); check("R12", "lo overlaid", 32'(rd), 32'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule